// File: doc/BRIEF.md
# Interrupt Mask and Serial-Bit Controller

This block sits beside a small processor core. It holds one mask bit for each of three vectored interrupt lines and turns the lines into masked requests for the core. The most urgent line, line 2, is caught on its rising edge and held until software or the core lets it go. Lines 1 and 0 are passed through as levels.

The same block also drives one serial output bit and reports one serial input bit. Software controls everything with a single control byte. A write of that byte can load the masks, drop the held line-2 request without servicing it, and update the serial output bit. Each of these three actions has its own enable bit inside the byte, so one write can do any mix of them. A status byte is always present on the output. It carries the masks, the three pending flags and the serial input level. Because control and status are single-cycle register accesses, both are plain pins with no valid/ready handshake: a write takes effect on the clock edge where `ctl_we` is high, and the status byte is valid in every cycle.

Top module: `irqm_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, all three mask bits read 1, the line-2 request is clear, `ser_out` is 0 and `irq_req` is 0.
- R2: A control write with bit 3 set loads control bits 2..0 into mask bits 2..0 (bit n masks line n, where 1 means masked). The new masks appear in `stat_byte[2:0]` in the cycle after the write edge.
- R3: A control write with bit 3 clear leaves the masks unchanged, whatever control bits 2..0 hold.
- R4: A rising edge on `irq_line[2]` (low in one sampled cycle, high in the next) sets the line-2 pending flag, visible in `stat_byte[6]` one cycle later. The flag stays set after the line falls. The edge sampler resets to low, so a line that is already high when reset ends counts as an edge.
- R5: The line-2 pending flag is cleared either by a control write with bit 4 set or by `top_ack`. If a new rising edge arrives in the same cycle as a clear, the flag stays set.
- R6: `stat_byte[5]` follows `irq_line[1]` and `stat_byte[4]` follows `irq_line[0]` in the same cycle; these lines are not latched.
- R7: `irq_req[n]` is 1 exactly when line n is pending and its mask bit is 0. The pending flags are `stat_byte[6:4]`, for lines 2..0.
- R8: A control write with bit 6 set drives control bit 7 onto `ser_out` from the next cycle. With bit 6 clear, `ser_out` holds its value.
- R9: `stat_byte[7]` is the current `ser_in` level, and `stat_byte[3]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte: [7] serial data, [6] serial update enable, [4] line-2 clear, [3] mask load enable, [2:0] masks |
| stat_byte | output | 8 | Status byte: [7] serial in, [6:4] pending lines 2..0, [3] zero, [2:0] masks |
| irq_line | input | 3 | Interrupt lines; line 2 edge-captured, lines 1 and 0 level |
| top_ack | input | 1 | Core acknowledge of the line-2 request |
| ser_in | input | 1 | Serial input bit |
| ser_out | output | 1 | Serial output bit |
| irq_req | output | 3 | Masked requests to the core |

## Verification
The checker tests the following on every cycle:
- a mask load happens only when its enable bit is set, and the masks hold otherwise;
- the serial output changes only on an enabled write;
- an edge on line 2 always sets its flag, and the flag stays set until a clear or acknowledge arrives without a competing edge;
- the request outputs always equal the pending flags with the masked lines removed.

Other behaviours only appear in the bench's scenarios: a line that is already high when reset ends, a clear that lands in the same cycle as a fresh edge, the low lines following their inputs level for level, and writes that mix the three enables in one byte. The bench compares all of these against its reference model on every clock.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int LINES    = 3;
  localparam int BYTE_W   = 8;
  localparam int TOP_LINE = LINES - 1;

  // Bit positions inside the status byte.
  localparam int ST_MASK_LSB = 0;
  localparam int ST_PEND_LSB = 4;
  localparam int ST_SIN_BIT  = 7;

  typedef struct packed {
    logic             so_data;   // [7]
    logic             so_upd;    // [6]
    logic             spare;     // [5]
    logic             clr_top;   // [4]
    logic             mask_ld;   // [3]
    logic [LINES-1:0] mask;      // [2:0]
  } ctl_byte_t;
endpackage

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '1;
    else if (load) mask <= din;
  end
endmodule

// File: rtl/irqm_edge_latch.sv
module irqm_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  output logic pend
);
  logic line_q;
  logic rise;

  assign rise = line & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      line_q <= line;
      // A new edge outranks a clear in the same cycle.
      pend   <= rise | (pend & ~clr);
    end
  end
endmodule

// File: rtl/irqm_sout_reg.sv
module irqm_sout_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic din,
  output logic sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sout <= 1'b0;
    else if (upd) sout <= din;
  end
endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_byte,
  output logic [BYTE_W-1:0] stat_byte,
  input  logic [LINES-1:0]  irq_line,
  input  logic              top_ack,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [LINES-1:0]  irq_req
);
  ctl_byte_t        ctl;
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] pending;

  assign ctl = ctl_byte;

  irqm_mask_reg #(.W(LINES)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ctl_we & ctl.mask_ld),
    .din  (ctl.mask),
    .mask (mask_q)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == TOP_LINE) begin : g_edge
      irqm_edge_latch u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .line (irq_line[i]),
        .clr  ((ctl_we & ctl.clr_top) | top_ack),
        .pend (pending[i])
      );
    end else begin : g_level
      assign pending[i] = irq_line[i];
    end
  end

  irqm_sout_reg u_sout (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (ctl_we & ctl.so_upd),
    .din  (ctl.so_data),
    .sout (ser_out)
  );

  assign irq_req = pending & ~mask_q;

  always_comb begin
    stat_byte = '0;
    stat_byte[ST_MASK_LSB +: LINES] = mask_q;
    stat_byte[ST_PEND_LSB +: LINES] = pending;
    stat_byte[ST_SIN_BIT]           = ser_in;
  end
endmodule

// File: rtl/irqm_ctrl_chk.sv
module irqm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_byte,
  input logic [7:0] stat_byte,
  input logic [2:0] irq_line,
  input logic       top_ack,
  input logic       ser_in,
  input logic       ser_out,
  input logic [2:0] irq_req
);
  logic top_q;
  logic top_rise;
  logic top_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= 1'b0;
    else        top_q <= irq_line[2];
  end

  assign top_rise = irq_line[2] & ~top_q;
  assign top_clr  = (ctl_we & ctl_byte[4]) | top_ack;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_byte[3]) |=> stat_byte[2:0] == $past(ctl_byte[2:0])); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && ctl_byte[3]) |=> $stable(stat_byte[2:0])); // R3

  AST_TOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    top_rise |=> stat_byte[6]); // R4

  AST_TOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[6] && !top_clr) |=> stat_byte[6]); // R4

  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (top_clr && !top_rise) |=> !stat_byte[6]); // R5

  AST_REQ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (stat_byte[6:4] & ~stat_byte[2:0])); // R7

  AST_SOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_byte[6]) |=> ser_out == $past(ctl_byte[7])); // R8

  AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && ctl_byte[6]) |=> $stable(ser_out)); // R8

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_byte[3]); // R9
endmodule

bind irqm_ctrl irqm_ctrl_chk u_chk (.*);

// File: tb/test_irqm_ctrl.sv
`timescale 1ns/1ps
module test_irqm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_byte = 8'h00;
  logic [7:0] stat_byte;
  logic [2:0] irq_line = 3'b000;
  logic       top_ack = 1'b0;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic [2:0] irq_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference state
  logic [2:0] m_mask = 3'b111;
  logic       m_pend = 1'b0;
  logic       m_prev = 1'b0;
  logic       m_sout = 1'b0;

  always #2 clk = ~clk;

  irqm_ctrl i_irqm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .stat_byte(stat_byte), .irq_line(irq_line), .top_ack(top_ack),
    .ser_in(ser_in), .ser_out(ser_out), .irq_req(irq_req)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [2:0] pend;
    pend = {m_pend, irq_line[1:0]};
    cmp({tag, "/R2"}, "mask bits", int'(stat_byte[2:0]), int'(m_mask));
    cmp({tag, "/R4"}, "line2 pending", int'(stat_byte[6]), int'(m_pend));
    cmp({tag, "/R6"}, "level pending", int'(stat_byte[5:4]), int'(irq_line[1:0]));
    cmp({tag, "/R9"}, "serial in and spare", int'({stat_byte[7], stat_byte[3]}), int'({ser_in, 1'b0}));
    cmp({tag, "/R7"}, "requests", int'(irq_req), int'(pend & ~m_mask));
    cmp({tag, "/R8"}, "serial out", int'(ser_out), int'(m_sout));
  endtask

  // Called at a negedge: apply inputs, check, then advance one clock.
  task automatic step(input logic we, input logic [7:0] b, input logic [2:0] ln,
                      input logic ack, input logic si, input string tag);
    logic rise;
    logic clr;
    ctl_we = we; ctl_byte = b; irq_line = ln; top_ack = ack; ser_in = si;
    #1;
    compare_all(tag);
    rise = ln[2] & ~m_prev;
    clr  = (we & b[4]) | ack;
    @(posedge clk);
    m_pend = rise | (m_pend & ~clr);
    m_prev = ln[2];
    if (we && b[3]) m_mask = b[2:0];
    if (we && b[6]) m_sout = b[7];
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state held while rst_n is low
    repeat (3) @(negedge clk);
    #1;
    cmp("R1", "reset status", int'(stat_byte), 8'h07);
    cmp("R1", "reset requests", int'(irq_req), 0);
    cmp("R1", "reset serial out", int'(ser_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 8'h00, 3'b011, 1'b0, 1'b0, "R1");   // levels present, all masked

    // R2: load masks 010
    step(1'b1, 8'h0A, 3'b000, 1'b0, 1'b0, "R2");
    step(1'b0, 8'h00, 3'b011, 1'b0, 1'b0, "R2");
    // R3: bits 2..0 without load enable
    step(1'b1, 8'h05, 3'b011, 1'b0, 1'b0, "R3");
    step(1'b0, 8'h00, 3'b011, 1'b0, 1'b1, "R3");
    // R6: level lines follow inputs
    step(1'b0, 8'h00, 3'b001, 1'b0, 1'b1, "R6");
    step(1'b0, 8'h00, 3'b010, 1'b0, 1'b0, "R6");
    // Unmask everything
    step(1'b1, 8'h08, 3'b000, 1'b0, 1'b0, "R2");
    // R4: edge capture then line falls
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R4");
    // R5: clear by control bit 4
    step(1'b1, 8'h10, 3'b000, 1'b0, 1'b0, "R5");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R5");
    // R5: clear by acknowledge
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R5");
    step(1'b0, 8'h00, 3'b100, 1'b1, 1'b0, "R5");
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R5");  // held high: no new edge
    // R5: edge coinciding with clear keeps the flag
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R5");
    step(1'b1, 8'h10, 3'b100, 1'b0, 1'b0, "R5");
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R5");
    // R7: mask line 2 while pending
    step(1'b1, 8'h0C, 3'b111, 1'b0, 1'b0, "R7");
    step(1'b0, 8'h00, 3'b011, 1'b0, 1'b0, "R7");
    // R8: serial out update and gated write
    step(1'b1, 8'hC0, 3'b000, 1'b0, 1'b0, "R8");
    step(1'b1, 8'h00, 3'b000, 1'b0, 1'b0, "R8");
    step(1'b1, 8'h40, 3'b000, 1'b0, 1'b0, "R8");
    step(1'b1, 8'h80, 3'b000, 1'b0, 1'b0, "R8");
    // Mixed: all three enables in one byte
    step(1'b1, 8'hDD, 3'b000, 1'b0, 1'b1, "R8");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R9");
    // Random traffic
    for (int n = 0; n < 300; n++) begin
      step(1'($urandom_range(0, 1)), 8'($urandom), 3'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom), "R7");
    end
    // R1: reset while line 2 is high; it counts as an edge afterwards
    irq_line = 3'b100;
    rst_n = 1'b0;
    #1;
    cmp("R1", "re-reset status", int'(stat_byte & 8'h4F), 8'h07);
    cmp("R1", "re-reset serial out", int'(ser_out), 0);
    m_mask = 3'b111; m_pend = 1'b0; m_prev = 1'b0; m_sout = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R4");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule